// File: doc/BRIEF.md
# Three-Phase Signed Waveform Gain Stage

This block trims the amplitude of three phase-voltage sample streams. Every phase has its own signed 24-bit gain word. A new sample on phase k is multiplied by one plus that word divided by 2^23. A word of zero leaves the sample unchanged. The most negative word removes the sample entirely. The largest positive word almost doubles it. The result is rounded toward negative infinity and clamped to the signed sample range instead of wrapping.

All three phases share one valid strobe. The strobe runs through the same two register stages as the data, so the output strobe marks exactly the cycles that carry scaled samples. Between valid samples the outputs hold their last value.

A small register port writes and reads the gain words. Inside the block each word is kept sign-extended to 28 bits. A read returns that 28-bit value with four zero bits above it, forming a 32-bit word.

Top module: `wgain_stage`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `out_samp` is 0 and every gain word reads back as 0, which gives unity gain.
- R2: A write with `reg_wr`=1 to address k (0, 1 or 2 for phase A, B, C) stores `reg_wdata[23:0]` as phase k's gain. Bits 31:24 of the written word are ignored. A read of address k on `reg_rdata` gives bits 31:28 = 0, bits 27:24 = copies of bit 23, and bits 23:0 = the stored word.
- R3: For a sample x and a gain word g (both two's complement), the output is floor(x·(2^23+g)/2^23), saturated to the signed sample width.
- R4: A gain of 0x400000 gives 1.5·x, and 0xC00000 gives 0.5·x. The 0.5·x result is rounded down, so x=-1 gives -1 and x=1 gives 0.
- R5: When the result goes above 2^23-1 the output is 0x7FFFFF. When it goes below -2^23 the output is 0x800000. A gain of 0x800000 gives 0.
- R6: `out_valid` is high exactly two clock cycles after `in_valid` was high. The scaled sample is on `out_samp` in that same cycle.
- R7: A sample presented in the same cycle as a gain write uses the old gain. A sample presented in any later cycle uses the new gain.
- R8: A write to one phase's gain changes neither the outputs nor the readback of the other two phases.
- R9: A write to address 3 changes no gain word. A read of address 3 returns 0.
- R10: While `out_valid` is 0, `out_samp` holds its previous value, whatever `in_samp` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| in_valid | input | 1 | Marks a new sample on all three phases |
| in_samp | input | 72 | Phase k sample at bits [24k+23:24k], signed |
| reg_wr | input | 1 | Gain write strobe |
| reg_addr | input | 2 | Gain word select: 0, 1 or 2 for phase A, B, C; 3 is unused |
| reg_wdata | input | 32 | Write data; bits 23:0 hold the gain |
| reg_rdata | output | 32 | Gain word at `reg_addr`, read combinationally |
| out_valid | output | 1 | Marks a scaled sample |
| out_samp | output | 72 | Scaled samples, same packing as `in_samp` |

## Verification
The checker relies on three things about the inputs:
- `rst_n` is held low for at least a couple of clock edges, so the internal synchronizer and all pipeline registers start cleared.
- Every input changes only away from the rising clock edge.
- `reg_addr` carries a defined value whenever the readback word is checked.

The stimulus meets these conditions in three ways:
- It drives every input on the falling edge.
- It keeps reset low for several cycles before the first operation.
- It always leaves `reg_addr` pointing at a legal or deliberately unused address.

Arithmetic cases are chosen where rounding and saturation land exactly on the limits.

// File: rtl/wgain_pkg.sv
package wgain_pkg;
  localparam int DEF_SAMPLE_W = 24;
  localparam int DEF_GAIN_W   = 24;
  localparam int DEF_STORE_W  = 28;
  localparam int DEF_BUS_W    = 32;
  localparam int DEF_FRAC_W   = 23;
  localparam int DEF_NPH      = 3;
  localparam int DEF_ADDR_W   = 2;

  // Latency from in_valid to out_valid: multiply stage plus output register
  localparam int PIPE_DEPTH = 2;

  typedef enum logic [1:0] {
    SEL_PH_A = 2'd0,
    SEL_PH_B = 2'd1,
    SEL_PH_C = 2'd2,
    SEL_NONE = 2'd3
  } phase_sel_e;
endpackage

// File: rtl/wgain_regs.sv
module wgain_regs #(
  parameter int NPH     = 3,
  parameter int GAIN_W  = 24,
  parameter int STORE_W = 28,
  parameter int BUS_W   = 32,
  parameter int ADDR_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_W-1:0]      wdata,
  output logic [BUS_W-1:0]      rdata,
  output logic [NPH*GAIN_W-1:0] gains
);
  localparam int EXT_W = STORE_W - GAIN_W;
  localparam int PAD_W = BUS_W - STORE_W;

  logic [STORE_W-1:0] word_q [NPH];
  logic [STORE_W-1:0] word_d [NPH];
  logic [BUS_W-GAIN_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = wdata[BUS_W-1:GAIN_W];

  for (genvar k = 0; k < NPH; k++) begin : g_word
    always_comb begin
      word_d[k] = word_q[k];
      if (wr_en && addr == ADDR_W'(k))
        word_d[k] = {{EXT_W{wdata[GAIN_W-1]}}, wdata[GAIN_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[k] <= '0;
      else if (wr_en)
        word_q[k] <= word_d[k];
    end

    assign gains[k*GAIN_W +: GAIN_W] = word_q[k][GAIN_W-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NPH; k++)
      if (addr == ADDR_W'(k))
        rdata = {{PAD_W{1'b0}}, word_q[k]};
  end
endmodule

// File: rtl/wgain_lane.sv
module wgain_lane #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 24,
  parameter int FRAC_W   = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_mul,
  input  logic                ld_out,
  input  logic [SAMPLE_W-1:0] x,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMPLE_W-1:0] y
);
  localparam int FACT_W  = GAIN_W + 1;
  localparam int PROD_W  = SAMPLE_W + FACT_W;
  localparam int SHIFT_W = PROD_W - FRAC_W;
  localparam int TOP_W   = SHIFT_W - SAMPLE_W + 1;
  localparam logic signed [FACT_W-1:0] UNITY =
    {{(FACT_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  logic signed [FACT_W-1:0]  factor;
  logic signed [PROD_W-1:0]  prod_d;
  logic signed [SHIFT_W-1:0] prod_q;
  logic [FRAC_W-1:0]         unused_lsbs;
  logic [SAMPLE_W-1:0]       y_d;
  logic [TOP_W-1:0]          top_bits;

  // Next-state: unity plus the Q-fraction gain, full-precision product
  always_comb begin
    factor = $signed({gain[GAIN_W-1], gain}) + UNITY;
    prod_d = $signed(x) * factor;
  end

  // Keeping only the bits above the fraction is an arithmetic shift (floor)
  assign unused_lsbs = prod_d[FRAC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prod_q <= '0;
    else if (ld_mul)
      prod_q <= prod_d[PROD_W-1:FRAC_W];
  end

  // Saturate: every bit from the sample sign upward must agree
  assign top_bits = prod_q[SHIFT_W-1:SAMPLE_W-1];

  always_comb begin
    if (top_bits == '0 || top_bits == '1)
      y_d = prod_q[SAMPLE_W-1:0];
    else if (prod_q[SHIFT_W-1])
      y_d = {1'b1, {(SAMPLE_W-1){1'b0}}};
    else
      y_d = {1'b0, {(SAMPLE_W-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      y <= '0;
    else if (ld_out)
      y <= y_d;
  end
endmodule

// File: rtl/wgain_stage.sv
module wgain_stage
  import wgain_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int GAIN_W   = DEF_GAIN_W,
  parameter int STORE_W  = DEF_STORE_W,
  parameter int BUS_W    = DEF_BUS_W,
  parameter int FRAC_W   = DEF_FRAC_W,
  parameter int NPH      = DEF_NPH,
  parameter int ADDR_W   = DEF_ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NPH*SAMPLE_W-1:0] in_samp,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [BUS_W-1:0]        reg_wdata,
  output logic [BUS_W-1:0]        reg_rdata,
  output logic                    out_valid,
  output logic [NPH*SAMPLE_W-1:0] out_samp
);
  logic [1:0]              rst_pipe;
  logic                    rst_q;
  logic [NPH*GAIN_W-1:0]   gain_bus;
  logic [PIPE_DEPTH-1:0]   vld_q;
  logic [PIPE_DEPTH-1:0]   vld_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  wgain_regs #(
    .NPH(NPH), .GAIN_W(GAIN_W), .STORE_W(STORE_W),
    .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_q),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .gains (gain_bus)
  );

  assign vld_d = {vld_q[PIPE_DEPTH-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)
      vld_q <= '0;
    else
      vld_q <= vld_d;
  end
  assign out_valid = vld_q[PIPE_DEPTH-1];

  for (genvar k = 0; k < NPH; k++) begin : g_lane
    wgain_lane #(
      .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_q),
      .ld_mul (in_valid),
      .ld_out (vld_q[0]),
      .x      (in_samp[k*SAMPLE_W +: SAMPLE_W]),
      .gain   (gain_bus[k*GAIN_W +: GAIN_W]),
      .y      (out_samp[k*SAMPLE_W +: SAMPLE_W])
    );
  end
endmodule

// File: rtl/wgain_chk.sv
module wgain_chk #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 24,
  parameter int STORE_W  = 28,
  parameter int BUS_W    = 32,
  parameter int NPH      = 3,
  parameter int ADDR_W   = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic [NPH*SAMPLE_W-1:0] out_samp,
  input logic                    reg_wr,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [BUS_W-1:0]        reg_rdata,
  input logic [NPH*GAIN_W-1:0]   gains
);
  localparam int EXT_W = STORE_W - GAIN_W + 1;

  logic [1:0] in_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      in_hist <= '0;
    else
      in_hist <= {in_hist[0], in_valid};
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == in_hist[1]);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_samp));

  // R9
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(NPH)) |=> $stable(gains));

  // R2
  read_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[BUS_W-1:STORE_W] == '0 &&
    (reg_rdata[STORE_W-1:GAIN_W-1] == '0 ||
     reg_rdata[STORE_W-1:GAIN_W-1] == {EXT_W{1'b1}}));
endmodule

bind wgain_stage wgain_chk #(
  .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .STORE_W(STORE_W),
  .BUS_W(BUS_W), .NPH(NPH), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_samp  (out_samp),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .gains     (gain_bus)
);

// File: tb/tb_wgain_stage.sv
`timescale 1ns/1ps
module tb_wgain_stage;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [71:0] in_samp;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        out_valid;
  logic [71:0] out_samp;

  int checks = 0;
  int failures = 0;
  logic [23:0] gmodel [3];

  wgain_stage dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samp(in_samp),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .out_valid(out_valid), .out_samp(out_samp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint x, input logic [23:0] g);
    longint gs, p, q;
    gs = longint'($signed(g));
    p  = x * (64'sd8388608 + gs);
    q  = p >>> 23;
    if (q > 8388607)  q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  function automatic longint lane(input int k);
    return longint'($signed(out_samp[k*24 +: 24]));
  endfunction

  task automatic wr_gain(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a != 2'd3) gmodel[a] = d[23:0];
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, longint'(reg_rdata), longint'(exp));
  endtask

  // Present one sample on each phase, check all three two edges later
  task automatic send(input string req, input longint x0, input longint x1, input longint x2);
    longint xs [3];
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    @(negedge clk);
    in_valid = 1'b1;
    in_samp = {x2[23:0], x1[23:0], x0[23:0]};
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid early"}, longint'(out_valid), 0);
    @(negedge clk);
    check({req, " valid"}, longint'(out_valid), 1);
    for (int k = 0; k < 3; k++)
      check(req, lane(k), model(xs[k], gmodel[k]));
  endtask

  task automatic t_reset;
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 out_samp", longint'(out_samp), 0);
    for (int k = 0; k < 3; k++) rd_check("R1 gain", 2'(k), 32'h0);
    send("R1 unity", 1234, -5678, 8388607);
  endtask

  task automatic t_readback;
    wr_gain(2'd0, 32'hFF80_0001);
    rd_check("R2 negative", 2'd0, 32'h0F80_0001);
    wr_gain(2'd1, 32'h123F_FFFF);
    rd_check("R2 positive", 2'd1, 32'h003F_FFFF);
    rd_check("R8 untouched", 2'd2, 32'h0);
    wr_gain(2'd0, 32'h0); wr_gain(2'd1, 32'h0);
  endtask

  task automatic t_half;
    wr_gain(2'd0, 32'h0040_0000);
    wr_gain(2'd1, 32'h00C0_0000);
    wr_gain(2'd2, 32'h00C0_0000);
    send("R4 half", 2000, 2000, -1);
    send("R4 round", -2000, 1, -3);
    check("R4 plus50", lane(0), -3000);
    check("R4 floor", lane(1), 0);
    check("R4 floorneg", lane(2), -2);
  endtask

  task automatic t_general;
    wr_gain(2'd0, 32'h0012_3456);
    wr_gain(2'd1, 32'h00F3_0001);
    wr_gain(2'd2, 32'h0080_0000);
    send("R3 mix", 777777, -4242421, 3000000);
    check("R5 zero gain", lane(2), 0);
    send("R3 mix2", -1, 8388607, -8388608);
  endtask

  task automatic t_sat;
    wr_gain(2'd0, 32'h007F_FFFF);
    wr_gain(2'd1, 32'h007F_FFFF);
    wr_gain(2'd2, 32'h0060_0000);
    send("R5 sat", 8388607, -8388608, 5000000);
    check("R5 max", lane(0), 8388607);
    check("R5 min", lane(1), -8388608);
    check("R5 max2", lane(2), 8388607);
  endtask

  task automatic t_timing;
    wr_gain(2'd0, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0040_0000;
    in_valid = 1'b1; in_samp = {24'd0, 24'd0, 24'd1000};
    @(negedge clk);
    reg_wr = 1'b0;
    in_samp = {24'd0, 24'd0, 24'd1000};
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 old gain", lane(0), 1000);
    check("R6 valid", longint'(out_valid), 1);
    @(negedge clk);
    check("R7 new gain", lane(0), 1500);
    gmodel[0] = 24'h400000;
  endtask

  task automatic t_indep;
    wr_gain(2'd1, 32'h0);
    wr_gain(2'd2, 32'h0);
    wr_gain(2'd2, 32'h00C0_0000);
    send("R8 indep", 400, 400, 400);
    check("R8 phase A", lane(0), 600);
    check("R8 phase B", lane(1), 400);
  endtask

  task automatic t_hole;
    wr_gain(2'd3, 32'h0040_0000);
    rd_check("R9 read hole", 2'd3, 32'h0);
    rd_check("R9 A kept", 2'd0, 32'h0040_0000);
    rd_check("R9 B kept", 2'd1, 32'h0);
    rd_check("R9 C kept", 2'd2, 32'h0FC0_0000);
    send("R9 outputs", 100, 100, 100);
  endtask

  task automatic t_hold;
    logic [71:0] snap;
    snap = out_samp;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_samp = {24'hABCDEF, 24'h123456, 24'h654321};
    end
    @(negedge clk);
    check("R10 hold", longint'(out_samp == snap), 1);
    check("R10 idle", longint'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_samp = '0;
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    for (int k = 0; k < 3; k++) gmodel[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_readback;
    t_half;
    t_general;
    t_sat;
    t_timing;
    t_indep;
    t_hole;
    t_hold;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule